// File: doc/BRIEF.md
# Cosine K-means Cluster Engine

This engine sorts a block of 64 key vectors into 4 groups by direction, using cosine similarity. Software or an upstream unit writes the keys one token at a time through an indexed write port and then pulses `start`. The engine first scales every key to unit length. It does this with the key's self dot product and a 64-entry reciprocal-square-root table. It then alternates an assignment pass and a centroid update pass.

In the assignment pass each key takes the label of the centroid it has the largest dot product with. In the update pass each centroid becomes the unit-length sum of its members. The rounds end when a round changes no label, or after `MAX_ITER` rounds. The engine then raises `done`.

The labels come from keys alone. A consumer elsewhere applies the label of token *t* to the value vector of token *t*. Labels and centroids are read through two combinational read ports.

Top module: `cosine_cluster_engine`

## Requirements
- R1: While the engine is idle, `keyWrEn` stores `keyWrVec` as the key of token `keyWrIdx`. Element *d* sits in bits [d*16 +: 16] as signed two's complement. Writes made while a run is in progress are ignored and have no effect on the run's labels.
- R2: After reset, `done` is 0, every label reads 0, and every centroid reads all zeros.
- R3: A run performs at most `MAX_ITER` assign/update rounds (default 16). With `MAX_ITER`=1, `done` is seen 133 cycles after the start edge.
- R4: Round 1 always counts as changed. A run stops after the first later round that changes no label. `done` is seen 64 + 68·R + 1 cycles after the start edge, where R is the number of rounds.
- R5: Each key's label is the index of the centroid with the largest dot product against the normalized key. The result therefore depends on direction only, not on magnitude.
- R6: The initial centroids are the normalized keys of tokens 0, 16, 32 and 48, in that order, for clusters 0 to 3.
- R7: When two or more similarities are equal, the lowest cluster index wins. An all-zero key therefore gets label 0.
- R8: A cluster with no members in a round keeps its previous centroid.
- R9: A non-empty cluster's new centroid is the normalized element-wise sum of its normalized members. Unit length is 2^(EW-2), which is 16384 by default.
- R10: Normalization multiplies by a table estimate of 1/sqrt of the self dot product. It gives a squared length within 1/8 of 2^(2·(EW-2)) for any nonzero input.
- R11: `done` falls at the start edge and rises one cycle after the final centroid update. It stays high until the next start. A `start` pulse during a run is ignored.
- R12: `rdLabel` shows the label of token `rdTok`, and `rdCent` shows centroid `rdCl` (same element layout as R1), both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyWrEn | input | 1 | Key write strobe |
| keyWrIdx | input | 6 | Token index of the key write |
| keyWrVec | input | 64 | Key vector, DIM elements of EW bits |
| start | input | 1 | Begin a clustering run (pulse) |
| done | output | 1 | Run finished; results valid |
| rdTok | input | 6 | Token index for label readout |
| rdLabel | output | 2 | Cluster label of token `rdTok` |
| rdCl | input | 2 | Cluster index for centroid readout |
| rdCent | output | 64 | Centroid vector of cluster `rdCl` |

## Verification
A corrupted round counter or a lost change flag does not stay hidden. It moves the rise of `done` by a whole 68-cycle round, so a latency check that is exact to the cycle catches it as soon as the run ends. Errors in the seed choice, the argmax, the tie order or the accumulators show up in the label table and the centroid values read right after `done`. The datasets are chosen so every label and several centroid elements are known exactly or within tight bounds. A write or start that leaks into a running engine would shift a label or the latency of that same run.

// File: rtl/km_pkg.sv
package km_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NORM,
    S_ASSIGN,
    S_UPDATE,
    S_FIN
  } kmState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrOk;      // external key writes allowed
    logic normKey;   // normalize key[tok] in place
    logic seedCent;  // load initial centroids
    logic clrAcc;    // clear sums and member counts
    logic doAssign;  // label key[tok], accumulate it
    logic updCent;   // refresh centroid[cl]
  } kmStrobe_t;

endpackage

// File: rtl/km_norm.sv
module km_norm #(
  parameter int DIM = 4,
  parameter int IW  = 22,
  parameter int EW  = 16
) (
  input  logic [DIM*IW-1:0] vin,
  output logic [DIM*EW-1:0] vout,
  output logic              nonZero
);
  localparam int SW = 2*IW + $clog2(DIM);
  localparam int PW = $clog2(SW);
  localparam int LW = EW;
  localparam int MW = IW + LW + 1;

  // 1/sqrt(idx/16) scaled by 2^(EW-2), valid for idx in 16..63
  function automatic longint unsigned rsqrtEntry(int idx);
    longint unsigned tgt, r, t;
    if (idx < 16) return 0;
    tgt = (64'd1 << (2*EW)) / longint'(idx);
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= tgt) r = t;
    end
    return r;
  endfunction

  logic [LW-1:0] lut [64];
  for (genvar i = 0; i < 64; i++) begin : g_lut
    localparam longint unsigned LV = rsqrtEntry(i);
    assign lut[i] = LW'(LV);
  end

  logic signed [IW-1:0]   el   [DIM];
  logic signed [2*IW-1:0] wide [DIM];
  logic [2*IW-1:0]        sqd  [DIM];
  logic signed [MW-1:0]   prodN [DIM];

  logic [SW-1:0] sq;
  logic [PW-1:0] lead;
  logic [PW-1:0] q;
  logic [5:0]    idx;
  logic [LW-1:0] inv;

  for (genvar d = 0; d < DIM; d++) begin : g_el
    assign el[d]    = vin[d*IW +: IW];
    assign wide[d]  = (2*IW)'(el[d]);
    assign sqd[d]   = wide[d] * wide[d];
    assign prodN[d] = MW'(el[d]) * $signed({1'b0, inv});
    assign vout[d*EW +: EW] = EW'(prodN[d] >>> q);
  end

  always_comb begin
    sq = '0;
    for (int d = 0; d < DIM; d++) sq = sq + SW'(sqd[d]);
  end

  always_comb begin
    lead = '0;
    for (int b = 0; b < SW; b++) if (sq[b]) lead = PW'(b);
    q = lead >> 1;
    if (int'(q) >= 2) idx = 6'(sq >> (2*int'(q) - 4));
    else              idx = 6'(sq << (4 - 2*int'(q)));
    inv = lut[idx];
  end

  assign nonZero = |sq;

endmodule

// File: rtl/km_ctrl.sv
module km_ctrl
  import km_pkg::*;
#(
  parameter int TOKENS   = 64,
  parameter int K        = 4,
  parameter int MAX_ITER = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       labelChg,
  output kmStrobe_t                  stb,
  output logic [$clog2(TOKENS)-1:0]  tok,
  output logic [$clog2(K)-1:0]       cl,
  output logic                       done
);
  localparam int TW  = $clog2(TOKENS);
  localparam int KW  = $clog2(K);
  localparam int ITW = $clog2(MAX_ITER + 1);
  localparam logic [TW-1:0] LAST_TOK = TW'(TOKENS - 1);
  localparam logic [KW-1:0] LAST_CL  = KW'(K - 1);

  kmState_e       state;
  logic [ITW-1:0] iterCnt;
  logic           changed;
  logic           stopNow;

  assign stopNow = !changed || (iterCnt == ITW'(MAX_ITER - 1));

  always_comb begin
    stb          = '0;
    stb.wrOk     = (state == S_IDLE);
    stb.normKey  = (state == S_NORM);
    stb.seedCent = (state == S_NORM) && (tok == LAST_TOK);
    stb.clrAcc   = ((state == S_NORM) && (tok == LAST_TOK)) ||
                   ((state == S_UPDATE) && (cl == LAST_CL) && !stopNow);
    stb.doAssign = (state == S_ASSIGN);
    stb.updCent  = (state == S_UPDATE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tok     <= '0;
      cl      <= '0;
      iterCnt <= '0;
      changed <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_NORM;
          tok     <= '0;
          iterCnt <= '0;
          done    <= 1'b0;
        end
        S_NORM: begin
          tok <= tok + 1'b1;
          if (tok == LAST_TOK) begin
            state   <= S_ASSIGN;
            changed <= 1'b1;  // first round always counts as changed
          end
        end
        S_ASSIGN: begin
          tok     <= tok + 1'b1;
          changed <= changed | labelChg;
          if (tok == LAST_TOK) begin
            state <= S_UPDATE;
            cl    <= '0;
          end
        end
        S_UPDATE: begin
          cl <= cl + 1'b1;
          if (cl == LAST_CL) begin
            iterCnt <= iterCnt + 1'b1;
            if (stopNow) state <= S_FIN;
            else begin
              state   <= S_ASSIGN;
              changed <= 1'b0;
            end
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: round count never passes the cap
  p_iter_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= ITW'(MAX_ITER));

  // R4: a quiet round ends the run
  p_early_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UPDATE && cl == LAST_CL && !changed) |=> state == S_FIN);

  // R11: done rises only out of the finishing cycle
  p_done_late_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(state) == S_FIN);

  // R11: done stays low while a run is in progress
  p_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !done);

endmodule

// File: rtl/km_dp.sv
module km_dp
  import km_pkg::*;
#(
  parameter int TOKENS = 64,
  parameter int K      = 4,
  parameter int DIM    = 4,
  parameter int EW     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  kmStrobe_t                  stb,
  input  logic [$clog2(TOKENS)-1:0]  tok,
  input  logic [$clog2(K)-1:0]       cl,
  input  logic                       keyWrEn,
  input  logic [$clog2(TOKENS)-1:0]  keyWrIdx,
  input  logic [DIM*EW-1:0]          keyWrVec,
  input  logic [$clog2(TOKENS)-1:0]  rdTok,
  input  logic [$clog2(K)-1:0]       rdCl,
  output logic [$clog2(K)-1:0]       rdLabel,
  output logic [DIM*EW-1:0]          rdCent,
  output logic                       labelChg
);
  localparam int TW     = $clog2(TOKENS);
  localparam int KW     = $clog2(K);
  localparam int IW     = EW + TW;
  localparam int DTW    = 2*EW + $clog2(DIM) + 1;
  localparam int STRIDE = TOKENS / K;
  localparam longint ONE2   = 64'd1 << (2*(EW-2));
  localparam longint LEN_LO = ONE2 - ONE2/8;
  localparam longint LEN_HI = ONE2 + ONE2/8;

  logic [DIM*EW-1:0] keyMem   [TOKENS];
  logic [KW-1:0]     labelMem [TOKENS];
  logic [DIM*EW-1:0] cent     [K];
  logic [DIM*IW-1:0] acc      [K];
  logic [TW:0]       cnt      [K];

  logic [DIM*EW-1:0] curKey;
  logic [DIM*IW-1:0] keyExt;
  logic [DIM*IW-1:0] normIn;
  logic [DIM*EW-1:0] normOut;
  logic              normNz;
  logic signed [DTW-1:0] dot [K];
  logic signed [DTW-1:0] bestVal;
  logic [KW-1:0]     best;

  assign curKey = keyMem[tok];
  for (genvar d = 0; d < DIM; d++) begin : g_ext
    assign keyExt[d*IW +: IW] = IW'($signed(curKey[d*EW +: EW]));
  end
  assign normIn = stb.normKey ? keyExt : acc[cl];

  km_norm #(.DIM(DIM), .IW(IW), .EW(EW)) u_norm (
    .vin(normIn), .vout(normOut), .nonZero(normNz)
  );

  always_comb begin
    for (int j = 0; j < K; j++) begin
      dot[j] = '0;
      for (int d = 0; d < DIM; d++)
        dot[j] = dot[j] + DTW'($signed(curKey[d*EW +: EW])) *
                          DTW'($signed(cent[j][d*EW +: EW]));
    end
  end

  // strict compare: equal similarity keeps the lower index
  always_comb begin
    best    = '0;
    bestVal = dot[0];
    for (int j = 1; j < K; j++)
      if (dot[j] > bestVal) begin
        best    = KW'(j);
        bestVal = dot[j];
      end
  end

  assign labelChg = (best != labelMem[tok]);

  always_ff @(posedge clk) begin
    if (stb.wrOk && keyWrEn) keyMem[keyWrIdx] <= keyWrVec;
    if (stb.normKey)         keyMem[tok]      <= normOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOKENS; i++) labelMem[i] <= '0;
      for (int j = 0; j < K; j++) begin
        cent[j] <= '0;
        acc[j]  <= '0;
        cnt[j]  <= '0;
      end
    end else begin
      if (stb.seedCent)
        for (int j = 0; j < K; j++) cent[j] <= keyMem[j*STRIDE];
      if (stb.clrAcc)
        for (int j = 0; j < K; j++) begin
          acc[j] <= '0;
          cnt[j] <= '0;
        end
      if (stb.doAssign) begin
        labelMem[tok] <= best;
        cnt[best]     <= cnt[best] + 1'b1;
        for (int d = 0; d < DIM; d++)
          acc[best][d*IW +: IW] <= acc[best][d*IW +: IW] + keyExt[d*IW +: IW];
      end
      if (stb.updCent && cnt[cl] != '0) cent[cl] <= normOut;
    end
  end

  assign rdLabel = labelMem[rdTok];
  assign rdCent  = cent[rdCl];

  // ---------------- checks ----------------
  logic [TOKENS*DIM*EW-1:0] keyFlat;
  for (genvar t = 0; t < TOKENS; t++) begin : g_flat
    assign keyFlat[t*DIM*EW +: DIM*EW] = keyMem[t];
  end

  logic signed [DTW-1:0] outLen;
  always_comb begin
    outLen = '0;
    for (int d = 0; d < DIM; d++)
      outLen = outLen + DTW'($signed(normOut[d*EW +: EW])) *
                        DTW'($signed(normOut[d*EW +: EW]));
  end

  // R1: key store untouched outside idle writes and normalization
  p_hold_keys_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrOk && !stb.normKey) |=> $stable(keyFlat));

  // R10: normalized output has near-unit squared length
  p_unit_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.normKey || stb.updCent) && normNz) |->
      (outLen >= DTW'(LEN_LO) && outLen <= DTW'(LEN_HI)));

  for (genvar j = 0; j < K; j++) begin : g_chk
    // R5: chosen cluster is at least as similar as every other
    p_argmax_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.doAssign |-> dot[j] <= dot[best]);
    // R7: lower clusters are strictly less similar than the winner
    p_tie_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.doAssign && KW'(j) < best) |-> dot[j] < dot[best]);
    // R8: an empty cluster keeps its centroid
    p_empty_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.updCent && cl == KW'(j) && cnt[j] == '0) |=> $stable(cent[j]));
  end

endmodule

// File: rtl/cosine_cluster_engine.sv
module cosine_cluster_engine
  import km_pkg::*;
#(
  parameter int TOKENS   = 64,
  parameter int K        = 4,
  parameter int DIM      = 4,
  parameter int EW       = 16,
  parameter int MAX_ITER = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       keyWrEn,
  input  logic [$clog2(TOKENS)-1:0]  keyWrIdx,
  input  logic [DIM*EW-1:0]          keyWrVec,
  input  logic                       start,
  output logic                       done,
  input  logic [$clog2(TOKENS)-1:0]  rdTok,
  output logic [$clog2(K)-1:0]       rdLabel,
  input  logic [$clog2(K)-1:0]       rdCl,
  output logic [DIM*EW-1:0]          rdCent
);
  localparam int TW = $clog2(TOKENS);
  localparam int KW = $clog2(K);

  kmStrobe_t       stb;
  logic [TW-1:0]   tok;
  logic [KW-1:0]   cl;
  logic            labelChg;

  km_ctrl #(.TOKENS(TOKENS), .K(K), .MAX_ITER(MAX_ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .labelChg(labelChg),
    .stb(stb), .tok(tok), .cl(cl), .done(done)
  );

  km_dp #(.TOKENS(TOKENS), .K(K), .DIM(DIM), .EW(EW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tok(tok), .cl(cl),
    .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx), .keyWrVec(keyWrVec),
    .rdTok(rdTok), .rdCl(rdCl), .rdLabel(rdLabel), .rdCent(rdCent),
    .labelChg(labelChg)
  );

endmodule

// File: tb/tb_cosine_cluster_engine.sv
`timescale 1ns/1ps
module tb_cosine_cluster_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyWrEn = 1'b0;
  logic [5:0]  keyWrIdx = '0;
  logic [63:0] keyWrVec = '0;
  logic        start = 1'b0;
  logic [5:0]  rdTok = '0;
  logic [1:0]  rdCl = '0;
  logic        done, doneCap;
  logic [1:0]  rdLabel, rdLabelCap;
  logic [63:0] rdCent, rdCentCap;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cosine_cluster_engine dut (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx),
    .keyWrVec(keyWrVec), .start(start), .done(done), .rdTok(rdTok),
    .rdLabel(rdLabel), .rdCl(rdCl), .rdCent(rdCent)
  );

  cosine_cluster_engine #(.MAX_ITER(1)) dutCap (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx),
    .keyWrVec(keyWrVec), .start(start), .done(doneCap), .rdTok(rdTok),
    .rdLabel(rdLabelCap), .rdCl(rdCl), .rdCent(rdCentCap)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkVec(input int a0, input int a1, input int a2, input int a3);
    return {16'(a3), 16'(a2), 16'(a1), 16'(a0)};
  endfunction

  function automatic int grp(input int i);
    return (i + i/16) % 4;
  endfunction

  // Separated data: group g points along axis 3-g, widely varying magnitude
  function automatic logic [63:0] sepKey(input int i);
    int mag, n, ax;
    int e [4];
    if (i == 5) return '0;
    mag = 50 + (i*397) % 20000;
    n   = (((i*7) % 5) - 2) * mag / 64;
    ax  = 3 - grp(i);
    for (int d = 0; d < 4; d++) e[d] = (d == ax) ? mag : n;
    return mkVec(e[0], e[1], e[2], e[3]);
  endfunction

  task automatic loadAll(input bit sep);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      keyWrEn  = 1'b1;
      keyWrIdx = 6'(i);
      keyWrVec = sep ? sepKey(i) : mkVec(4096, 0, 0, 0);
    end
    @(negedge clk);
    keyWrEn = 1'b0;
  endtask

  // Pulse start, count cycles until done (and doneCap) are seen
  task automatic runWait(input bit poke, output int lat, output int latCap);
    int cnt;
    lat = -1;
    latCap = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (lat < 0 && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 20) begin
        keyWrEn = 1'b1; keyWrIdx = 6'd10; keyWrVec = mkVec(0, 0, 0, 20000);
      end
      if (poke && cnt == 21) keyWrEn = 1'b0;
      if (poke && cnt == 30) start = 1'b1;
      if (poke && cnt == 31) start = 1'b0;
      if (doneCap && latCap < 0) latCap = cnt;
      if (done) lat = cnt;
    end
  endtask

  task automatic t_reset;
    rdTok = 6'd7; rdCl = 2'd2; #1;
    chk(done == 1'b0, "R2 done after reset", done, 0);
    chk(rdLabel == 2'd0, "R2 label after reset", rdLabel, 0);
    chk(rdCent == '0, "R2 centroid after reset", rdCent != '0, 0);
  endtask

  task automatic t_separated;
    int lat, latCap, errs, errsCap, v;
    loadAll(1'b1);
    runWait(1'b1, lat, latCap);
    chk(lat == 201, "R4 R11 R1 two-round latency, stray start ignored", lat, 201);
    chk(latCap == 133, "R3 capped at one round", latCap, 133);
    errs = 0; errsCap = 0;
    for (int i = 0; i < 64; i++) begin
      int exp;
      exp = (i == 5) ? 0 : grp(i);
      rdTok = 6'(i); #1;
      if (rdLabel != 2'(exp)) errs++;
      if (rdLabelCap != 2'(exp)) errsCap++;
      // R5 direction-only labels, R6 seeds, R7 zero key -> 0, R1 token 10 write ignored
      if (i == 5 || i == 10 || i == 16 || i == 48)
        chk(rdLabel == 2'(exp), "R5 R6 R7 R1 label of probed token", rdLabel, exp);
    end
    chk(errs == 0, "R5 R12 label mismatches", errs, 0);
    chk(errsCap == 0, "R3 capped label mismatches", errsCap, 0);
    for (int c = 0; c < 4; c++) begin
      rdCl = 2'(c); #1;
      for (int d = 0; d < 4; d++) begin
        v = int'($signed(rdCent[d*16 +: 16]));
        if (d == 3 - c)
          chk(v >= 15500 && v <= 17100, "R9 centroid main axis", v, 16384);
        else
          chk(v > -2000 && v < 2000, "R9 centroid off axis", v, 0);
      end
    end
  endtask

  task automatic t_identical;
    int lat, latCap, errs;
    loadAll(1'b0);
    runWait(1'b0, lat, latCap);
    chk(lat == 201, "R4 identical keys latency", lat, 201);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      rdTok = 6'(i); #1;
      if (rdLabel != 2'd0) errs++;
    end
    chk(errs == 0, "R7 ties to cluster 0", errs, 0);
    for (int c = 0; c < 4; c++) begin
      rdCl = 2'(c); #1;
      // R8 clusters 1..3 empty keep seed; R9 R10 cluster 0 exact unit vector
      chk(rdCent == mkVec(16384, 0, 0, 0), "R8 R9 R10 centroid exact",
          longint'($signed(rdCent[15:0])), 16384);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_separated();
    t_identical();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule